// File: doc/BRIEF.md
# Dual-Bank Task-Tagged Address Translation Buffer

This block translates a 32-bit virtual address into a physical address through a combinational search of every stored entry at once. It holds two independent banks of 32 entries each. One bank serves privileged code and the other serves unprivileged code, and a privilege input picks the bank for every operation.

Each entry stores four things: a 23-bit virtual page number, a 5-bit task identifier, a valid flag and a 3-bit size mask. Together these make the 29-bit searchable tag plus its mask. The entry also holds a 28-bit data word made of a 23-bit physical page number and 5 attribute bits. The mask lets an entry cover 512 B, 1 KB, 2 KB or 4 KB.

Replacement follows least-recently-used order, kept in one 5-bit age counter per entry. A miss is only flagged: external logic fetches the mapping and writes it back through the fill port. A flush port drops every entry of one task in one cycle, which makes context switches cheap.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry of both banks is invalid. Any lookup then gives lk_hit=0 and lk_miss=1.
- R2: priv_sup=1 selects the supervisor bank and priv_sup=0 selects the user bank, for lookup, fill and flush alike. An operation on one bank never changes the other bank.
- R3: A lookup (lk_valid=1) hits only if three conditions hold for an entry of the selected bank: it is valid, its task equals cur_task, and every unmasked page bit equals lk_vaddr[31:9]. lk_hit follows in the same cycle.
- R4: Mask bit k set (fill_mask[k]) drops virtual address bit 9+k from the compare. The same position of lk_paddr then comes from lk_vaddr. lk_paddr[8:0] always equals lk_vaddr[8:0], and the other page bits come from the stored physical page number.
- R5: On a hit, lk_attr carries the stored attribute bits. On a miss, or with no lookup, lk_paddr and lk_attr are zero.
- R6: flush_en=1 clears the valid flag of every entry in the selected bank whose task equals flush_task, within the same clock edge. Entries of other tasks stay valid.
- R7: A hit sets the hit entry's age to 0. Every entry younger than that entry's old age ages by one, so the 32 ages stay a permutation of 0..31.
- R8: A fill goes to the lowest-numbered invalid entry. If no entry is invalid, it goes to the entry whose age is 31. The filled entry becomes the most recently used.
- R9: When more than one entry matches, lk_multi=1 and lk_paddr and lk_attr come from the lowest-numbered match.
- R10: A lookup that misses raises lk_miss=lk_valid and leaves all valid flags and ages unchanged.
- R11: Within one cycle, flush takes priority over fill, and fill takes priority over the age update of a lookup. A lookup that shares a cycle with a fill or flush still reports its result, but it does not change any age.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_sup | input | 1 | 1 = supervisor bank, 0 = user bank |
| cur_task | input | 5 | Task identifier used in the lookup compare |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_miss | output | 1 | Lookup found no matching entry |
| lk_multi | output | 1 | More than one entry matched |
| lk_paddr | output | 32 | Translated physical address |
| lk_attr | output | 5 | Attribute bits of the hit entry |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | 23 | Virtual page number of the new entry |
| fill_task | input | 5 | Task identifier of the new entry |
| fill_mask | input | 3 | Size mask of the new entry |
| fill_ppn | input | 23 | Physical page number of the new entry |
| fill_attr | input | 5 | Attribute bits of the new entry |
| flush_en | input | 1 | Invalidate all entries of one task |
| flush_task | input | 5 | Task identifier to invalidate |

## Verification
A corrupted valid flag or tag shows up as a wrong lk_hit, lk_miss or lk_paddr on the very next lookup of that page, in the same cycle as the lookup. A corrupted age counter stays hidden until a fill lands in a full bank. At that point the wrong entry is evicted, which shows as an unexpected miss on the next lookup of a page that should have survived. For that reason, the bench fills a bank to capacity and then probes both the evicted page and its neighbours. A mistake in the priority between flush, fill and lookup shows only when they share a cycle, so the bench drives that case on purpose.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // operation a bank carries out on the next clock edge
   typedef enum logic [1:0] {
      BANK_IDLE,
      BANK_TOUCH,
      BANK_FILL,
      BANK_FLUSH
   } bank_op_e;
endpackage

// File: rtl/xlat_prienc.sv
// Lowest-index-first priority encoder.
module xlat_prienc #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/xlat_age.sv
// Per-entry age counters forming a permutation of 0..N-1.
module xlat_age #(
   parameter int N  = 32,
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [AW-1:0] touch_idx,
   output logic [AW-1:0] oldest_idx
);
   logic [AW-1:0] age_q [N];
   logic [AW-1:0] pivot;
   logic [N-1:0]  is_old;
   logic          old_any;

   assign pivot = age_q[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (touch_idx == AW'(i))  age_q[i] <= '0;
            else if (age_q[i] < pivot) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   for (genvar e = 0; e < N; e++) begin : g_old
      assign is_old[e] = (age_q[e] == AW'(N - 1));
   end

   xlat_prienc #(.N(N), .IW(AW)) u_oldest (
      .req (is_old),
      .idx (oldest_idx),
      .any (old_any)
   );

   // R7
   one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      old_any && $onehot(is_old));

   // R7
   touched_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/xlat_bank.sv
// One fully associative bank: tag store, compare, data store, replacement.
module xlat_bank
   import xlat_pkg::*;
#(
   parameter int N      = 32,
   parameter int AW     = 5,
   parameter int VPN_W  = 23,
   parameter int TID_W  = 5,
   parameter int MASK_W = 3,
   parameter int ATTR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              lk_en,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [TID_W-1:0]  cur_tid,
   input  logic              wr_en,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [TID_W-1:0]  wr_tid,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [VPN_W-1:0]  wr_ppn,
   input  logic [ATTR_W-1:0] wr_attr,
   input  logic              inv_en,
   input  logic [TID_W-1:0]  inv_tid,
   output logic              hit,
   output logic              multi,
   output logic [VPN_W-1:0]  hit_ppn,
   output logic [ATTR_W-1:0] hit_attr
);
   localparam int DATA_W = VPN_W + ATTR_W;
   localparam int PAD_W  = VPN_W - MASK_W;

   logic [N-1:0]        valid_q;
   logic [VPN_W-1:0]    vpn_q  [N];
   logic [TID_W-1:0]    tid_q  [N];
   logic [MASK_W-1:0]   msk_q  [N];
   logic [DATA_W-1:0]   data_q [N];

   logic [N-1:0]        match;
   logic [N-1:0]        flush_hit;
   logic [AW-1:0]       hit_idx;
   logic [AW-1:0]       free_idx;
   logic [AW-1:0]       old_idx;
   logic [AW-1:0]       slot;
   logic [AW-1:0]       touch_idx;
   logic                any_free;
   bank_op_e            op;

   // parallel compare of every entry
   for (genvar e = 0; e < N; e++) begin : g_cmp
      logic [VPN_W-1:0] care;
      assign care         = ~{{PAD_W{1'b0}}, msk_q[e]};
      assign match[e]     = valid_q[e] && (tid_q[e] == cur_tid) &&
                            (((vpn_q[e] ^ lk_vpn) & care) == '0);
      assign flush_hit[e] = (tid_q[e] == inv_tid);
   end

   xlat_prienc #(.N(N), .IW(AW)) u_hit (
      .req (match),
      .idx (hit_idx),
      .any (hit)
   );

   xlat_prienc #(.N(N), .IW(AW)) u_free (
      .req (~valid_q),
      .idx (free_idx),
      .any (any_free)
   );

   assign multi = (match & (match - 1'b1)) != '0;
   assign slot  = any_free ? free_idx : old_idx;

   // masked page bits pass through from the virtual page number
   logic [VPN_W-1:0] keep;
   logic [DATA_W-1:0] sel_data;
   assign keep     = {{PAD_W{1'b0}}, msk_q[hit_idx]};
   assign sel_data = data_q[hit_idx];
   assign hit_ppn  = (sel_data[DATA_W-1:ATTR_W] & ~keep) | (lk_vpn & keep);
   assign hit_attr = sel_data[ATTR_W-1:0];

   always_comb begin
      op = BANK_IDLE;
      if (sel) begin
         if (inv_en)           op = BANK_FLUSH;
         else if (wr_en)       op = BANK_FILL;
         else if (lk_en && hit) op = BANK_TOUCH;
      end
   end

   assign touch_idx = (op == BANK_FILL) ? slot : hit_idx;

   xlat_age #(.N(N), .AW(AW)) u_age (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   ((op == BANK_FILL) || (op == BANK_TOUCH)),
      .touch_idx  (touch_idx),
      .oldest_idx (old_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (op == BANK_FLUSH && flush_hit[i]) valid_q[i] <= 1'b0;
            if (op == BANK_FILL && slot == AW'(i)) valid_q[i] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (op == BANK_FILL && slot == AW'(i)) begin
            vpn_q[i]  <= wr_vpn;
            tid_q[i]  <= wr_tid;
            msk_q[i]  <= wr_mask;
            data_q[i] <= {wr_ppn, wr_attr};
         end
      end
   end

   // R6
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == BANK_FLUSH) |=> (valid_q & $past(flush_hit)) == '0);

   // R10
   idle_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == BANK_IDLE) |=> $stable(valid_q));

   // R8
   fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == BANK_FILL) |=> valid_q[$past(slot)]);

   // R8
   fill_free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == BANK_FILL) && !(&valid_q)) |-> !valid_q[slot]);
endmodule

// File: rtl/xlat_tlb.sv
// Two-bank task-tagged translation buffer.
module xlat_tlb #(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 32,
   parameter int OFS_W   = 9,
   parameter int TID_W   = 5,
   parameter int MASK_W  = 3,
   parameter int ATTR_W  = 5,
   parameter int BANKS   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    priv_sup,
   input  logic [TID_W-1:0]        cur_task,
   input  logic                    lk_valid,
   input  logic [VA_W-1:0]         lk_vaddr,
   output logic                    lk_hit,
   output logic                    lk_miss,
   output logic                    lk_multi,
   output logic [VA_W-1:0]         lk_paddr,
   output logic [ATTR_W-1:0]       lk_attr,
   input  logic                    fill_en,
   input  logic [VA_W-OFS_W-1:0]   fill_vpn,
   input  logic [TID_W-1:0]        fill_task,
   input  logic [MASK_W-1:0]       fill_mask,
   input  logic [VA_W-OFS_W-1:0]   fill_ppn,
   input  logic [ATTR_W-1:0]       fill_attr,
   input  logic                    flush_en,
   input  logic [TID_W-1:0]        flush_task
);
   localparam int VPN_W = VA_W - OFS_W;
   localparam int AGE_W = $clog2(ENTRIES);

   if ((1 << AGE_W) != ENTRIES) begin : g_bad_depth
      $error("ENTRIES must be a power of two");
   end
   if (MASK_W >= VPN_W || OFS_W < 1) begin : g_bad_mask
      $error("MASK_W must be narrower than the page number");
   end
   if (BANKS != 2) begin : g_bad_banks
      $error("exactly two privilege banks are supported");
   end

   logic [BANKS-1:0]  b_hit;
   logic [BANKS-1:0]  b_multi;
   logic [VPN_W-1:0]  b_ppn  [BANKS];
   logic [ATTR_W-1:0] b_attr [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      xlat_bank #(
         .N      (ENTRIES),
         .AW     (AGE_W),
         .VPN_W  (VPN_W),
         .TID_W  (TID_W),
         .MASK_W (MASK_W),
         .ATTR_W (ATTR_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (priv_sup == b[0]),
         .lk_en    (lk_valid),
         .lk_vpn   (lk_vaddr[VA_W-1:OFS_W]),
         .cur_tid  (cur_task),
         .wr_en    (fill_en),
         .wr_vpn   (fill_vpn),
         .wr_tid   (fill_task),
         .wr_mask  (fill_mask),
         .wr_ppn   (fill_ppn),
         .wr_attr  (fill_attr),
         .inv_en   (flush_en),
         .inv_tid  (flush_task),
         .hit      (b_hit[b]),
         .multi    (b_multi[b]),
         .hit_ppn  (b_ppn[b]),
         .hit_attr (b_attr[b])
      );
   end

   logic found;
   assign found    = lk_valid && b_hit[priv_sup];
   assign lk_hit   = found;
   assign lk_miss  = lk_valid && !b_hit[priv_sup];
   assign lk_multi = found && b_multi[priv_sup];
   assign lk_paddr = found ? {b_ppn[priv_sup], lk_vaddr[OFS_W-1:0]} : '0;
   assign lk_attr  = found ? b_attr[priv_sup] : '0;

   // R3
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_miss));

   // R9
   multi_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> lk_hit);

   // R5
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_paddr == '0 && lk_attr == '0));

   // R4
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]);
endmodule

// File: tb/xlat_tlb_test.sv
`timescale 1ns/1ps
module xlat_tlb_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        priv_sup = 1'b0;
   logic [4:0]  cur_task = '0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_miss, lk_multi;
   logic [31:0] lk_paddr;
   logic [4:0]  lk_attr;
   logic        fill_en = 1'b0;
   logic [22:0] fill_vpn = '0;
   logic [4:0]  fill_task = '0;
   logic [2:0]  fill_mask = '0;
   logic [22:0] fill_ppn = '0;
   logic [4:0]  fill_attr = '0;
   logic        flush_en = 1'b0;
   logic [4:0]  flush_task = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   xlat_tlb uut (.*);

   // behavioural reference state
   bit          m_v    [2][32];
   logic [22:0] m_vpn  [2][32];
   logic [4:0]  m_tid  [2][32];
   logic [2:0]  m_msk  [2][32];
   logic [22:0] m_ppn  [2][32];
   logic [4:0]  m_attr [2][32];
   int          m_age  [2][32];

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic int find(int b, logic [22:0] vpn, logic [4:0] tid, output int cnt);
      int first = -1;
      cnt = 0;
      for (int i = 0; i < 32; i++) begin
         logic [22:0] care = ~{20'b0, m_msk[b][i]};
         if (m_v[b][i] && m_tid[b][i] == tid && ((m_vpn[b][i] ^ vpn) & care) == 0) begin
            cnt++;
            if (first < 0) first = i;
         end
      end
      return first;
   endfunction

   function automatic void touch(int b, int k);
      int old = m_age[b][k];
      for (int i = 0; i < 32; i++)
         if (m_age[b][i] < old) m_age[b][i]++;
      m_age[b][k] = 0;
   endfunction

   always @(posedge clk) begin
      int b, slot, k, cnt;
      if (!rst_n) begin
         for (int bb = 0; bb < 2; bb++)
            for (int i = 0; i < 32; i++) begin
               m_v[bb][i] = 0;
               m_age[bb][i] = i;
            end
      end else begin
         b = priv_sup ? 1 : 0;
         if (flush_en) begin
            for (int i = 0; i < 32; i++)
               if (m_tid[b][i] == flush_task) m_v[b][i] = 0;
         end else if (fill_en) begin
            slot = -1;
            for (int i = 0; i < 32; i++) if (!m_v[b][i] && slot < 0) slot = i;
            if (slot < 0)
               for (int i = 0; i < 32; i++) if (m_age[b][i] == 31) slot = i;
            m_v[b][slot] = 1;
            m_vpn[b][slot] = fill_vpn;
            m_tid[b][slot] = fill_task;
            m_msk[b][slot] = fill_mask;
            m_ppn[b][slot] = fill_ppn;
            m_attr[b][slot] = fill_attr;
            touch(b, slot);
         end else if (lk_valid) begin
            k = find(b, lk_vaddr[31:9], cur_task, cnt);
            if (k >= 0) touch(b, k);
         end
      end
   end

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      int b, k, cnt;
      logic eh, em, emu;
      logic [31:0] epa;
      logic [4:0] eat;
      logic [22:0] mk;
      if (rst_n && !done) begin
         b = priv_sup ? 1 : 0;
         k = find(b, lk_vaddr[31:9], cur_task, cnt);
         eh = lk_valid && k >= 0;
         em = lk_valid && k < 0;
         emu = eh && cnt > 1;
         epa = '0;
         eat = '0;
         if (eh) begin
            mk = {20'b0, m_msk[b][k]};
            epa = {(m_ppn[b][k] & ~mk) | (lk_vaddr[31:9] & mk), lk_vaddr[8:0]};
            eat = m_attr[b][k];
         end
         chk(lk_hit === eh, "R3", "hit", lk_hit, eh);
         chk(lk_miss === em, "R10", "miss", lk_miss, em);
         chk(lk_multi === emu, "R9", "multi", lk_multi, emu);
         chk(lk_paddr === epa, "R4", "paddr", lk_paddr, epa);
         chk(lk_attr === eat, "R5", "attr", lk_attr, eat);
      end
   end

   task automatic drive_clear();
      lk_valid = 0;
      fill_en = 0;
      flush_en = 0;
   endtask

   task automatic do_fill(bit m, logic [22:0] vpn, logic [4:0] tid, logic [2:0] msk,
                          logic [22:0] ppn, logic [4:0] attr);
      @(posedge clk); #1;
      drive_clear();
      priv_sup = m;
      fill_vpn = vpn; fill_task = tid; fill_mask = msk;
      fill_ppn = ppn; fill_attr = attr;
      fill_en = 1;
   endtask

   task automatic do_flush(bit m, logic [4:0] tid);
      @(posedge clk); #1;
      drive_clear();
      priv_sup = m;
      flush_task = tid;
      flush_en = 1;
   endtask

   task automatic look(bit m, logic [22:0] vpn, logic [4:0] tid, bit exp, string rq);
      @(posedge clk); #1;
      drive_clear();
      priv_sup = m;
      cur_task = tid;
      lk_vaddr = {vpn, 9'h0AB};
      lk_valid = 1;
      @(negedge clk);
      chk(lk_hit === exp, rq, "directed hit", lk_hit, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: empty after reset in both banks
      look(1, 23'h10, 3, 0, "R1");
      chk(lk_miss === 1'b1, "R1", "miss after reset", lk_miss, 1);
      look(0, 23'h10, 3, 0, "R1");

      // R2: same page, different bank contents
      do_fill(1, 23'h10, 3, 3'b000, 23'h111, 5'h11);
      do_fill(0, 23'h10, 3, 3'b000, 23'h222, 5'h02);
      look(1, 23'h10, 3, 1, "R2");
      chk(lk_paddr === {23'h111, 9'h0AB}, "R2", "supervisor paddr", lk_paddr, {23'h111, 9'h0AB});
      chk(lk_attr === 5'h11, "R5", "supervisor attr", lk_attr, 5'h11);
      look(0, 23'h10, 3, 1, "R2");
      chk(lk_paddr === {23'h222, 9'h0AB}, "R2", "user paddr", lk_paddr, {23'h222, 9'h0AB});

      // R3: wrong task misses
      look(1, 23'h10, 4, 0, "R3");

      // R4: 4 KB entry
      do_fill(1, 23'h20, 3, 3'b111, 23'h1238, 5'h07);
      look(1, 23'h25, 3, 1, "R4");
      chk(lk_paddr === {23'h123D, 9'h0AB}, "R4", "masked paddr", lk_paddr, {23'h123D, 9'h0AB});
      look(1, 23'h28, 3, 0, "R4");

      // R6: flush one task in the supervisor bank
      do_fill(1, 23'h30, 4, 3'b000, 23'h333, 5'h03);
      do_flush(1, 3);
      look(1, 23'h10, 3, 0, "R6");
      look(1, 23'h20, 3, 0, "R6");
      look(1, 23'h30, 4, 1, "R6");
      look(0, 23'h10, 3, 1, "R6");

      // R9: overlapping entries
      do_fill(1, 23'h50, 4, 3'b000, 23'h500, 5'h05);
      do_fill(1, 23'h51, 4, 3'b001, 23'h510, 5'h06);
      look(1, 23'h50, 4, 1, "R9");
      chk(lk_multi === 1'b1, "R9", "multi flag", lk_multi, 1);
      chk(lk_paddr === {23'h500, 9'h0AB}, "R9", "lowest index data", lk_paddr, {23'h500, 9'h0AB});
      look(1, 23'h51, 4, 1, "R9");
      chk(lk_multi === 1'b0, "R9", "single match", lk_multi, 0);

      // R7/R8: fill the user bank, age some entries, evict
      do_flush(0, 3);
      for (int i = 0; i < 32; i++)
         do_fill(0, 23'd100 + 23'(i), 1, 3'b000, 23'h4000 + 23'(i), 5'(i));
      for (int i = 0; i < 5; i++) look(0, 23'd100 + 23'(i), 1, 1, "R7");
      look(0, 23'd999, 1, 0, "R10");
      do_fill(0, 23'd200, 1, 3'b000, 23'h4200, 5'h1F);

      // R11: fill and hitting lookup in one cycle
      @(posedge clk); #1;
      drive_clear();
      priv_sup = 0;
      fill_vpn = 23'd201; fill_task = 1; fill_mask = 0; fill_ppn = 23'h4201; fill_attr = 5'h1E;
      fill_en = 1;
      cur_task = 1;
      lk_vaddr = {23'd106, 9'h0AB};
      lk_valid = 1;
      @(negedge clk);
      chk(lk_hit === 1'b1, "R11", "lookup during fill", lk_hit, 1);

      look(0, 23'd106, 1, 0, "R11");
      look(0, 23'd201, 1, 1, "R11");
      look(0, 23'd105, 1, 0, "R8");
      look(0, 23'd200, 1, 1, "R8");
      look(0, 23'd100, 1, 1, "R7");
      look(0, 23'd107, 1, 1, "R7");
      look(1, 23'h30, 4, 1, "R2");

      @(posedge clk); #1;
      drive_clear();
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule